// File: doc/BRIEF.md
# Chip Select Address Remapper

This block turns the chip-select field of a user address into a one-hot physical chip-select vector. A programmable population mask marks which physical chip-select lines have memory behind them. The logical index taken from the address is assigned to the populated lines in rising bit order. The lowest populated line takes index 0, the next populated line takes index 1, and so on. As a result the user address range stays gap-free for any arrangement of populated lines.

The number of populated lines must be a power of two. Only as many low index bits as that population needs are decoded. When the mask breaks the rule, the block flags a configuration error and drives every chip select inactive. Results are registered and appear one clock after a request is accepted. Between requests the output holds its last value.

Top module: `cs_remap`

## Requirements
- R1: While reset is applied, and until the first request after reset is accepted, `cs_sel_o` is all zero and `cfg_err_o` is 0.
- R2: Bit i of `cs_mask_i` enables physical chip select i. For a valid mask and logical index k, `cs_sel_o` has exactly one bit set. That bit is the position of the k-th set mask bit, counting the set bits from bit 0 upward with the first one numbered 0.
- R3: Only the low log2(P) bits of `cs_index_i` are used, where P is the number of set mask bits. Higher index bits do not change the result: index k selects the same line as k mod P.
- R4: An all-zero mask sets `cfg_err_o` to 1 and makes `cs_sel_o` all zero.
- R5: A mask whose population is not a power of two sets `cfg_err_o` to 1 and makes `cs_sel_o` all zero. A power-of-two population clears `cfg_err_o` to 0.
- R6: A request is taken on a rising clock edge where `req_valid_i` is 1. The result shows on the outputs right after that edge and not before it.
- R7: While `req_valid_i` is 0, both outputs keep their values, whatever the mask and index inputs do.
- R8: A selected line is always one whose mask bit was set in the accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req_valid_i | input | 1 | Request strobe; the mask and index are sampled while it is high |
| cs_mask_i | input | CS_W | Population mask, one bit per physical chip select |
| cs_index_i | input | IDX_W | Logical chip-select index from the user address |
| cs_sel_o | output | CS_W | Registered one-hot physical chip-select vector |
| cfg_err_o | output | 1 | Registered flag: the mask population is zero or not a power of two |

## Verification
The bench is built with four chip selects. It sweeps every mask against every index and compares the result with a reference that scans the mask bit by bit. Sparse masks such as 0101, 1010 and 1001 show whether the rank is counted over set bits rather than over bit positions. Masks with a population of one or two, driven with large indexes, show that the high index bits are dropped. Masks with three set bits, and the zero mask, show the error path. Separate scenarios change the inputs while the strobe is low, and sample just before the capturing edge, to separate hold behaviour and latency from the decode itself.

// File: rtl/cs_remap_pkg.sv
package cs_remap_pkg;

  // True when v is a nonzero power of two.
  function automatic logic is_pow2(input logic [31:0] v);
    return (v != 32'd0) && ((v & (v - 32'd1)) == 32'd0);
  endfunction

endpackage

// File: rtl/cs_pop_check.sv
module cs_pop_check #(
  parameter int CS_W  = 2,
  parameter int CNT_W = $clog2(CS_W + 1)
) (
  input  logic [CS_W-1:0]  mask_i,
  output logic [CNT_W-1:0] pop_o,
  output logic             cfg_ok_o
);
  import cs_remap_pkg::*;

  logic [CNT_W-1:0] part [CS_W+1];

  assign part[0] = '0;

  // Running population count across the mask.
  generate
    for (genvar g = 0; g < CS_W; g++) begin : g_pop
      assign part[g+1] = part[g] + CNT_W'(mask_i[g]);
    end
  endgenerate

  assign pop_o    = part[CS_W];
  assign cfg_ok_o = is_pow2(32'(pop_o));
endmodule

// File: rtl/cs_rank_select.sv
module cs_rank_select #(
  parameter int CS_W  = 2,
  parameter int CNT_W = $clog2(CS_W + 1)
) (
  input  logic [CS_W-1:0]  mask_i,
  input  logic [CNT_W-1:0] target_i,
  output logic [CS_W-1:0]  sel_o
);
  // rank[g] counts the set mask bits below position g.
  logic [CNT_W-1:0] rank [CS_W+1];

  assign rank[0] = '0;

  generate
    for (genvar g = 0; g < CS_W; g++) begin : g_rank
      assign rank[g+1] = rank[g] + CNT_W'(mask_i[g]);
      assign sel_o[g]  = mask_i[g] && (rank[g] == target_i);
    end
  endgenerate
endmodule

// File: rtl/cs_remap.sv
module cs_remap #(
  parameter int CS_W  = 2,
  parameter int IDX_W = (CS_W > 1) ? $clog2(CS_W) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid_i,
  input  logic [CS_W-1:0]  cs_mask_i,
  input  logic [IDX_W-1:0] cs_index_i,
  output logic [CS_W-1:0]  cs_sel_o,
  output logic             cfg_err_o
);
  localparam int CNT_W = $clog2(CS_W + 1);
  localparam int EXT_W = (CNT_W > IDX_W) ? CNT_W : IDX_W;

  // Reset synchroniser: asynchronous assert, synchronous release.
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic [CNT_W-1:0] pop;
  logic             cfg_ok;
  logic [CNT_W-1:0] target;
  logic [CS_W-1:0]  sel;

  cs_pop_check #(.CS_W(CS_W), .CNT_W(CNT_W)) u_pop (
    .mask_i   (cs_mask_i),
    .pop_o    (pop),
    .cfg_ok_o (cfg_ok)
  );

  // Keep only the low log2(pop) index bits; pop is a power of two when valid.
  logic [EXT_W-1:0] idx_ext, pop_m1;
  assign idx_ext = EXT_W'(cs_index_i);
  assign pop_m1  = EXT_W'(pop) - EXT_W'(1);
  assign target  = CNT_W'(idx_ext & pop_m1);

  cs_rank_select #(.CS_W(CS_W), .CNT_W(CNT_W)) u_rank (
    .mask_i   (cs_mask_i),
    .target_i (target),
    .sel_o    (sel)
  );

  // Next-state logic.
  logic [CS_W-1:0] sel_d;
  logic            err_d;
  always_comb begin
    sel_d = cs_sel_o;
    err_d = cfg_err_o;
    if (req_valid_i) begin
      sel_d = cfg_ok ? sel : '0;
      err_d = !cfg_ok;
    end
  end

  // Register process.
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      cs_sel_o  <= '0;
      cfg_err_o <= 1'b0;
    end else begin
      cs_sel_o  <= sel_d;
      cfg_err_o <= err_d;
    end
  end

  // R2
  onehot_when_ok_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($past(req_valid_i) && !cfg_err_o) |-> ($countones(cs_sel_o) == 1));

  // R4
  err_blanks_sel_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cfg_err_o |-> (cs_sel_o == '0));

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !$past(req_valid_i) |-> ($stable(cs_sel_o) && $stable(cfg_err_o)));

  // R8
  sel_in_mask_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $past(req_valid_i) |-> ((cs_sel_o & ~$past(cs_mask_i)) == '0));

  // R5
  err_tracks_pop_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $past(req_valid_i) |-> (cfg_err_o == !$onehot($past(cs_mask_i)) &&
                            $countones($past(cs_mask_i)) != 2) ||
                           ($countones($past(cs_mask_i)) == 2 && !cfg_err_o) ||
                           ($countones($past(cs_mask_i)) == 4 && !cfg_err_o) ||
                           ($countones($past(cs_mask_i)) == 8 && !cfg_err_o));
endmodule

// File: tb/cs_remap_bench.sv
module cs_remap_bench;
  localparam int CS_W  = 4;
  localparam int IDX_W = 2;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             req_valid_i;
  logic [CS_W-1:0]  cs_mask_i;
  logic [IDX_W-1:0] cs_index_i;
  logic [CS_W-1:0]  cs_sel_o;
  logic             cfg_err_o;

  int n_cmp = 0;
  int n_bad = 0;

  always #2 clk = ~clk;  // 250 MHz

  cs_remap #(.CS_W(CS_W), .IDX_W(IDX_W)) u_cs_remap (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid_i (req_valid_i),
    .cs_mask_i   (cs_mask_i),
    .cs_index_i  (cs_index_i),
    .cs_sel_o    (cs_sel_o),
    .cfg_err_o   (cfg_err_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Reference: scan the mask for the (k mod pop)-th set bit.
  function automatic logic [CS_W:0] ref_model(input logic [CS_W-1:0] m, input int k);
    int p = 0;
    int seen = 0;
    logic [CS_W-1:0] s = '0;
    for (int i = 0; i < CS_W; i++) if (m[i]) p++;
    if (p == 0 || (p & (p - 1)) != 0) return {1'b1, {CS_W{1'b0}}};
    for (int i = 0; i < CS_W; i++) begin
      if (m[i]) begin
        if (seen == (k % p)) s[i] = 1'b1;
        seen++;
      end
    end
    return {1'b0, s};
  endfunction

  task automatic issue(input logic [CS_W-1:0] m, input logic [IDX_W-1:0] k);
    @(negedge clk);
    req_valid_i = 1'b1;
    cs_mask_i   = m;
    cs_index_i  = k;
    @(posedge clk);
    #1;
    req_valid_i = 1'b0;
  endtask

  task automatic t_reset;
    rst_n = 1'b0; req_valid_i = 1'b0; cs_mask_i = '0; cs_index_i = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 sel in reset", 32'(cs_sel_o), 32'h0);
    check("R1 err in reset", 32'(cfg_err_o), 32'h0);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(posedge clk);
    cs_mask_i = 4'b1111;
    #1;
    check("R1 sel after release", 32'(cs_sel_o), 32'h0);
    check("R1 err after release", 32'(cfg_err_o), 32'h0);
  endtask

  task automatic t_sweep;
    for (int m = 0; m < 16; m++) begin
      for (int k = 0; k < 4; k++) begin
        logic [CS_W:0] e;
        e = ref_model(4'(m), k);
        issue(4'(m), 2'(k));
        check($sformatf("R2 sel m=%0h k=%0d", m, k), 32'(cs_sel_o), 32'(e[CS_W-1:0]));
        check($sformatf("R5 err m=%0h k=%0d", m, k), 32'(cfg_err_o), 32'(e[CS_W]));
      end
    end
  endtask

  task automatic t_sparse;
    issue(4'b1010, 2'd1); check("R2 sparse 1010 k1", 32'(cs_sel_o), 32'h8);
    issue(4'b1001, 2'd0); check("R2 sparse 1001 k0", 32'(cs_sel_o), 32'h1);
    issue(4'b1001, 2'd1); check("R8 sparse 1001 k1", 32'(cs_sel_o), 32'h8);
  endtask

  task automatic t_high_bits;
    issue(4'b0110, 2'd3); check("R3 pop2 k3 wraps", 32'(cs_sel_o), 32'h4);
    issue(4'b0110, 2'd2); check("R3 pop2 k2 wraps", 32'(cs_sel_o), 32'h2);
    issue(4'b0100, 2'd3); check("R3 pop1 k3", 32'(cs_sel_o), 32'h4);
  endtask

  task automatic t_errors;
    issue(4'b0000, 2'd0);
    check("R4 zero mask err", 32'(cfg_err_o), 32'h1);
    check("R4 zero mask sel", 32'(cs_sel_o), 32'h0);
    issue(4'b1011, 2'd2);
    check("R5 pop3 err", 32'(cfg_err_o), 32'h1);
    check("R5 pop3 sel", 32'(cs_sel_o), 32'h0);
    issue(4'b1100, 2'd0);
    check("R5 recover err", 32'(cfg_err_o), 32'h0);
  endtask

  task automatic t_latency;
    issue(4'b0001, 2'd0);
    @(negedge clk);
    req_valid_i = 1'b1; cs_mask_i = 4'b1111; cs_index_i = 2'd2;
    @(posedge clk);
    #1;
    req_valid_i = 1'b0;
    check("R6 after edge", 32'(cs_sel_o), 32'h4);
    @(negedge clk);
    req_valid_i = 1'b1; cs_mask_i = 4'b1111; cs_index_i = 2'd3;
    #1.5;
    check("R6 before edge", 32'(cs_sel_o), 32'h4);
    @(posedge clk);
    #1;
    req_valid_i = 1'b0;
    check("R6 next edge", 32'(cs_sel_o), 32'h8);
  endtask

  task automatic t_hold;
    issue(4'b1111, 2'd1);
    check("R7 setup", 32'(cs_sel_o), 32'h2);
    @(negedge clk); cs_mask_i = 4'b0111; cs_index_i = 2'd3;
    @(negedge clk); cs_mask_i = 4'b0000; cs_index_i = 2'd0;
    repeat (3) @(posedge clk);
    #1;
    check("R7 sel held", 32'(cs_sel_o), 32'h2);
    check("R7 err held", 32'(cfg_err_o), 32'h0);
    issue(4'b0000, 2'd0);
    @(negedge clk); cs_mask_i = 4'b0001;
    repeat (2) @(posedge clk);
    #1;
    check("R7 err held high", 32'(cfg_err_o), 32'h1);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_sweep();
        t_sparse();
        t_high_bits();
        t_errors();
        t_latency();
        t_hold();
      end
      begin
        repeat (20000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule